// File: doc/BRIEF.md
# QoS Buffer-State Overwrite Selector

This block sits in the transmit path of a wireless MAC. For each outgoing frame it receives the 16-bit frame control word, the 16-bit QoS control word and three control bits: an overwrite enable, a station select and a source select. It returns the QoS control word, in which the upper octet (the buffer-state octet) may have been replaced by a value from a small programmable register file.

The register file has two station banks. Each bank holds one buffer-state byte per traffic identifier (TID) and one summed buffer-state byte. The station select picks the bank. The source select picks either the entry indexed by the TID carried in the frame's own QoS word or the bank's sum register. The replacement is made only on QoS data frames. Every other frame passes through untouched.

A plain write port loads the register file. Frames enter and leave over a valid/ready handshake, one frame per transfer, with one register stage between input and output.

Top module: `qbs_overwrite_sel`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and in_ready is 1. Every register-file entry reads as 0x00.
- R2: A frame is a QoS data frame when frame-control bits [3:2] equal 2'b10 and frame-control bit 7 is 1. Any other frame leaves the QoS word unchanged.
- R3: When the overwrite enable is 0, the output QoS word equals the input QoS word.
- R4: Bits [7:0] of the output QoS word always equal bits [7:0] of the input QoS word.
- R5: With the overwrite enable set on a QoS data frame and source select 0, output bits [15:8] take the TID entry of the bank chosen by station select (0 = bank 0, 1 = bank 1). The entry is indexed by the input QoS bits [3:0].
- R6: With source select 1 under the same conditions, output bits [15:8] take the sum register of the bank chosen by station select.
- R7: TID values 8 to 15 select the entry at TID modulo 8.
- R8: A register write takes effect for frames accepted from the next cycle on. A frame accepted in the same cycle as a write to its entry sees the old value.
- R9: A frame is transferred in when in_valid and in_ready are both 1, and out when out_valid and out_ready are both 1. in_ready is 0 whenever out_valid is 1 and out_ready is 0. While out_ready is 0, out_valid and out_qos hold. Results leave in the order the frames were accepted.
- R10: The write address is {wr_bank, wr_slot}. Slots 0 to 7 are TID entries and slot 8 is the sum register. A write to slot 9 to 15 changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register-file write strobe |
| wr_bank | input | 1 | Station bank addressed by the write |
| wr_slot | input | 4 | Slot within the bank: 0-7 TID, 8 sum |
| wr_data | input | 8 | Byte to store |
| in_valid | input | 1 | Frame present at the input |
| in_ready | output | 1 | Block can take a frame |
| in_fc | input | 16 | Frame control word |
| in_qos | input | 16 | QoS control word |
| in_ovr_en | input | 1 | Buffer-state overwrite enable |
| in_sta_sel | input | 1 | Station bank select |
| in_src_sel | input | 1 | 0 = TID-indexed entry, 1 = sum register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_qos | output | 16 | Resulting QoS control word |

## Verification
The bench sends TIDs above 7. A design that used all four TID bits would index past the table or return zero. It sends a frame together with a write to that frame's own entry. A design that forwarded the write data would show the new byte one frame early. It sends frames of management type, control type and data type without the QoS subtype bit, with the overwrite enable set. A design that looked only at the enable would corrupt their upper octet. Writes to the unused slots 9 to 15 are followed by reading back every entry of that bank. Random output backpressure checks that a stalled result holds and that results leave in order, with none dropped or repeated.

// File: rtl/qbs_pkg.sv
// Package: shared field positions and encodings for the QoS buffer-state
// overwrite selector. Assumes the non-11ah frame control layout.
package qbs_pkg;
    localparam int QOS_W       = 16;
    localparam int FC_W        = 16;
    localparam int OCTET_LSB   = 8;
    localparam int TYPE_LSB    = 2;
    localparam int SUBTYPE_QOS = 7;
    localparam logic [1:0] TYPE_DATA = 2'b10;

    typedef enum logic {
        SRC_TID = 1'b0,
        SRC_SUM = 1'b1
    } src_sel_e;

    // Returns 1 when the frame carries a meaningful QoS control field.
    function automatic logic is_qos_data(input logic [FC_W-1:0] fc);
        return (fc[TYPE_LSB +: 2] == TYPE_DATA) && fc[SUBTYPE_QOS];
    endfunction
endpackage

// File: rtl/qbs_bank_file.sv
// Module: flop-based register file of NUM_BANK station banks. Each bank holds
// NUM_TID buffer-state bytes and one sum byte. The write port addresses
// {bank, slot}: slots below NUM_TID hit TID entries, slot NUM_TID hits the sum
// register, and higher slots are dropped. The read is combinational from the
// current register contents, so a write becomes visible the cycle after it.
// Assumes NUM_TID is a power of two.
module qbs_bank_file #(
    parameter int NUM_BANK = 2,
    parameter int NUM_TID  = 8,
    parameter int BYTE_W   = 8,
    localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
    localparam int IDX_W   = $clog2(NUM_TID),
    localparam int SLOT_W  = $clog2(NUM_TID + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [IDX_W-1:0]  rd_tid,
    input  logic              rd_sum,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] bank_rd [NUM_BANK];

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic [BYTE_W-1:0] tid_q [NUM_TID];
        logic [BYTE_W-1:0] sum_q;
        logic              hit;

        // Decode whether this cycle's write targets this bank.
        assign hit = wr_en && (wr_bank == BANK_W'(b));

        // Store writes into TID entries; clear all on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NUM_TID; i++) tid_q[i] <= '0;
            end else if (hit && (wr_slot < SLOT_W'(NUM_TID))) begin
                tid_q[wr_slot[IDX_W-1:0]] <= wr_data;
            end
        end

        // Store writes into the sum register; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_q <= '0;
            end else if (hit && (wr_slot == SLOT_W'(NUM_TID))) begin
                sum_q <= wr_data;
            end
        end

        // Pick the sum or the indexed TID entry of this bank.
        assign bank_rd[b] = rd_sum ? sum_q : tid_q[rd_tid];
    end

    // Select the bank named by the station select.
    always_comb begin
        rd_data = bank_rd[0];
        for (int b = 1; b < NUM_BANK; b++) begin
            if (rd_bank == BANK_W'(b)) rd_data = bank_rd[b];
        end
    end
endmodule

// File: rtl/qbs_merge.sv
// Module: combinational merge. It replaces the buffer-state octet of the QoS
// word with the looked-up byte when overwrite is enabled on a QoS data frame.
// The low octet always passes through. Assumes BYTE_W fits the upper octet.
module qbs_merge
    import qbs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [FC_W-1:0]   fc,
    input  logic [QOS_W-1:0]  qos_in,
    input  logic              ovr_en,
    input  logic [BYTE_W-1:0] octet,
    output logic [QOS_W-1:0]  qos_out
);
    logic do_replace;
    logic unused_fc_bits;

    // Fold the frame control bits that play no part into a sink.
    assign unused_fc_bits = ^{fc[FC_W-1:SUBTYPE_QOS+1], fc[SUBTYPE_QOS-1:TYPE_LSB+2], fc[TYPE_LSB-1:0]};

    // Replace only when enabled and the QoS field is meaningful.
    assign do_replace = ovr_en && is_qos_data(fc);

    // Build the outgoing word, keeping the low octet untouched.
    always_comb begin
        qos_out = qos_in;
        if (do_replace) qos_out[OCTET_LSB +: BYTE_W] = octet;
    end
endmodule

// File: rtl/qbs_out_reg.sv
// Module: a single valid/ready register stage. It takes a new word whenever
// it is empty or its content leaves in the same cycle. in_ready depends
// combinationally on out_ready, because there is no skid entry.
module qbs_out_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    // Room exists when empty or draining this cycle.
    assign in_ready = !vld_q || out_ready;

    // Track occupancy of the stage.
    always_ff @(posedge clk) begin
        if (!rst_n)        vld_q <= 1'b0;
        else if (in_ready) vld_q <= in_valid;
    end

    // Capture the data word on every accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dat_q <= '0;
        else if (in_valid && in_ready)  dat_q <= in_data;
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;
endmodule

// File: rtl/qbs_overwrite_sel.sv
// Module: top of the QoS buffer-state overwrite selector. It looks up the
// station bank byte (TID-indexed or sum), merges it into the QoS word and
// registers the result behind a valid/ready stage. Latency is one cycle.
// Assumes the caller holds the frame inputs stable while in_valid waits.
module qbs_overwrite_sel
    import qbs_pkg::*;
#(
    parameter int NUM_TID  = 8,
    parameter int BYTE_W   = 8,
    localparam int NUM_BANK = 2,
    localparam int IDX_W    = $clog2(NUM_TID),
    localparam int SLOT_W   = $clog2(NUM_TID + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FC_W-1:0]   in_fc,
    input  logic [QOS_W-1:0]  in_qos,
    input  logic              in_ovr_en,
    input  logic              in_sta_sel,
    input  logic              in_src_sel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [QOS_W-1:0]  out_qos
);
    logic [BYTE_W-1:0] lookup;
    logic [QOS_W-1:0]  merged;
    logic              use_sum;

    // Decode the source selection into the bank file's sum select.
    assign use_sum = (src_sel_e'(in_src_sel) == SRC_SUM);

    qbs_bank_file #(
        .NUM_BANK (NUM_BANK),
        .NUM_TID  (NUM_TID),
        .BYTE_W   (BYTE_W)
    ) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .rd_bank (in_sta_sel),
        .rd_tid  (in_qos[IDX_W-1:0]),
        .rd_sum  (use_sum),
        .rd_data (lookup)
    );

    qbs_merge #(
        .BYTE_W (BYTE_W)
    ) u_merge (
        .fc      (in_fc),
        .qos_in  (in_qos),
        .ovr_en  (in_ovr_en),
        .octet   (lookup),
        .qos_out (merged)
    );

    qbs_out_reg #(
        .DATA_W (QOS_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (merged),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_qos)
    );
endmodule

// File: rtl/qbs_overwrite_sel_chk.sv
// Module: assertion checker attached to every qbs_overwrite_sel instance.
// It observes ports only and relates accepted inputs to the next result.
module qbs_overwrite_sel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] in_fc,
    input logic [15:0] in_qos,
    input logic        in_ovr_en,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_qos
);
    logic accept;
    assign accept = in_valid && in_ready;

    // R1: reset empties the output stage
    a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R9: an accepted frame produces a result on the next cycle
    a_r9_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R9: a stalled result holds its value
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_qos)));

    // R9: no intake while the stage is stalled
    a_r9_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R4: the low octet passes through
    a_r4_low_octet: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_qos[7:0] == $past(in_qos[7:0])));

    // R3: overwrite disabled leaves the word intact
    a_r3_no_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_ovr_en) |=> (out_qos == $past(in_qos)));

    // R2: frames without a QoS field pass through
    a_r2_non_qos: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !((in_fc[3:2] == 2'b10) && in_fc[7])) |=> (out_qos == $past(in_qos)));
endmodule

bind qbs_overwrite_sel qbs_overwrite_sel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_fc     (in_fc),
    .in_qos    (in_qos),
    .in_ovr_en (in_ovr_en),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_qos   (out_qos)
);

// File: tb/qbs_overwrite_sel_bench.sv
`timescale 1ns/1ps
module qbs_overwrite_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [3:0]  wr_slot = '0;
    logic [7:0]  wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_fc = '0;
    logic [15:0] in_qos = '0;
    logic        in_ovr_en = 1'b0;
    logic        in_sta_sel = 1'b0;
    logic        in_src_sel = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_qos;

    int checks = 0;
    int fails = 0;
    bit bp_on = 1'b0;
    bit done = 1'b0;

    logic [7:0] m_tid [2][8];
    logic [7:0] m_sum [2];
    logic [15:0] exp_q [$];
    string       tag_q [$];

    localparam logic [15:0] FC_QOS = 16'h0088;

    always #4 clk = ~clk;

    qbs_overwrite_sel u_qbs_overwrite_sel (.*);

    // Backpressure driver, changes away from both edges.
    always @(posedge clk) begin
        #2;
        out_ready <= bp_on ? ($urandom_range(2) != 0) : 1'b1;
    end

    function automatic logic [15:0] model(input logic [15:0] fc, input logic [15:0] q,
                                          input logic ovr, input logic sta, input logic src);
        logic [7:0] b;
        if (ovr && fc[3:2] == 2'b10 && fc[7]) begin
            b = src ? m_sum[sta] : m_tid[sta][q[2:0]];
            return {b, q[7:0]};
        end
        return q;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: scoreboard pop on transfers, plus hold check while stalled.
    bit         held = 1'b0;
    logic [15:0] held_val;
    always @(negedge clk) begin
        if (rst_n) begin
            if (held) begin
                check("R9 hold", {15'd0, out_valid} == 16'd1 ? out_qos : 16'hxxxx, held_val);
                held = 1'b0;
            end
            if (out_valid && !out_ready) begin
                held = 1'b1;
                held_val = out_qos;
                check("R9 stall blocks intake", {15'd0, in_ready}, 16'd0);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected result", out_qos, 16'hxxxx);
                end else begin
                    check(tag_q.pop_front(), out_qos, exp_q.pop_front());
                    void'(exp_q.size());
                end
            end
        end
    end

    // Send one frame; optionally a write in the same cycle.
    task automatic frame(input string tag, input logic [15:0] fc, input logic [15:0] q,
                         input logic ovr, input logic sta, input logic src,
                         input bit do_wr = 0, input logic wb = 0,
                         input logic [3:0] ws = 0, input logic [7:0] wd = 0);
        in_valid = 1'b1; in_fc = fc; in_qos = q;
        in_ovr_en = ovr; in_sta_sel = sta; in_src_sel = src;
        wr_en = do_wr; wr_bank = wb; wr_slot = ws; wr_data = wd;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        exp_q.push_back(model(fc, q, ovr, sta, src));
        tag_q.push_back(tag);
        @(posedge clk); #1;
        if (do_wr) begin
            if (ws < 8) m_tid[wb][ws[2:0]] = wd;
            else if (ws == 8) m_sum[wb] = wd;
        end
        in_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic write(input logic b, input logic [3:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_bank = b; wr_slot = s; wr_data = d;
        @(posedge clk); #1;
        if (s < 8) m_tid[b][s[2:0]] = d;
        else if (s == 8) m_sum[b] = d;
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            m_sum[b] = 8'h00;
            for (int t = 0; t < 8; t++) m_tid[b][t] = 8'h00;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {15'd0, out_valid}, 16'd0);
        check("R1 in_ready after reset", {15'd0, in_ready}, 16'd1);
        @(posedge clk); #1;
        // R1: entries cleared
        frame("R1 cleared tid entry", FC_QOS, 16'hAB05, 1, 1, 0);
        frame("R1 cleared sum", FC_QOS, 16'hCD02, 1, 0, 1);

        for (int t = 0; t < 8; t++) begin
            write(0, 4'(t), 8'(8'h10 + t));
            write(1, 4'(t), 8'(8'hA0 + t));
        end
        write(0, 4'd8, 8'h5C);
        write(1, 4'd8, 8'hC5);

        // R5: TID-indexed lookups in both banks
        for (int t = 0; t < 8; t++) begin
            frame("R5 tid bank0", FC_QOS, {8'h33, 4'h6, 4'(t)}, 1, 0, 0);
            frame("R5 tid bank1", FC_QOS, {8'h44, 4'h1, 4'(t)}, 1, 1, 0);
        end
        // R7: TIDs 8..15 wrap
        for (int t = 8; t < 16; t++) frame("R7 tid wrap", FC_QOS, {8'h99, 4'h0, 4'(t)}, 1, t[0], 0);
        // R6: sum registers
        frame("R6 sum bank0", FC_QOS, 16'h1207, 1, 0, 1);
        frame("R6 sum bank1", FC_QOS, 16'h3403, 1, 1, 1);
        // R3: overwrite disabled
        frame("R3 ovr off", FC_QOS, 16'hBEEF, 0, 1, 1);
        frame("R3 ovr off tid", FC_QOS, 16'h7702, 0, 0, 0);
        // R2: non-QoS frames
        frame("R2 mgmt type", 16'h0080, 16'h5A01, 1, 0, 0);
        frame("R2 data no qos bit", 16'h0008, 16'h5A01, 1, 1, 1);
        frame("R2 control type", 16'h0084, 16'h5A01, 1, 0, 1);
        // R4: low octet preserved under replacement
        frame("R4 low octet", FC_QOS, 16'h00FF, 1, 1, 1);
        drain();

        // R8: same-cycle write sees old value, next frame sees new
        frame("R8 same cycle old value", FC_QOS, 16'h0003, 1, 0, 0, 1, 0, 4'd3, 8'h77);
        frame("R8 next cycle new value", FC_QOS, 16'h0003, 1, 0, 0);
        frame("R8 same cycle sum old", FC_QOS, 16'h0000, 1, 1, 1, 1, 1, 4'd8, 8'h3E);
        frame("R8 sum new", FC_QOS, 16'h0000, 1, 1, 1);
        drain();

        // R10: writes to unused slots change nothing
        for (int s = 9; s < 16; s++) write(1, 4'(s), 8'hEE);
        for (int t = 0; t < 8; t++) frame("R10 tid untouched", FC_QOS, {8'h00, 4'h0, 4'(t)}, 1, 1, 0);
        frame("R10 sum untouched", FC_QOS, 16'h0000, 1, 1, 1);
        drain();

        // R9: ordering under random backpressure
        bp_on = 1'b1;
        for (int k = 0; k < 60; k++) begin
            frame("R9 ordered burst", (k % 5 == 0) ? 16'h0008 : FC_QOS,
                  16'(k * 16'h0137), 1, k[1], k[0]);
        end
        repeat (200) begin
            if (exp_q.size() == 0) break;
            @(posedge clk);
        end
        bp_on = 1'b0;
        drain();
        check("R9 all results delivered", 16'(exp_q.size()), 16'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule